// File: doc/BRIEF.md
# Shared-Memory Target Network Interface with Segment Reassembly

This block is the target side of a tile's network connection. Remote initiators reach the tile's shared data memory through two links: a point-to-point link and a shared bus. Each link carries one 16-bit data segment per transaction. Every transaction has a network word address, a direction flag and, for writes, a segment. The block accepts one transaction at a time. It maps the network address into the tile's shared region of the local data memory. It then competes for the single memory port by raising a request towards the tile's round-robin arbiter and holding it until the grant.

A local word is several segments wide. Write segments are collected in a per-link accumulator. A single full-width memory write is issued only when the final segment of the word arrives. Reads go the other way: the first segment request of a word fetches the whole word from memory, and the following segment requests are served from a held copy. Every network request is answered by exactly one acknowledge pulse. Read data is returned with that pulse.

Top module: `shared_slave_ni`

## Requirements
- R1: After synchronous reset, both link acknowledges and the memory request are low.
- R2: The memory address is the network word address minus the tile base (TILE_BASE), plus the shared-region offset (SHARED_OFS), taken modulo 2^MEM_AW.
- R3: Segment k of a write word lands in bits [16k+15:16k], with segment 0 least significant. Exactly one memory write per word is issued, and only after the final segment; earlier segments cause no memory request.
- R4: A write segment that is not the last of its word, and a read segment that is not the first, is acknowledged in the cycle after it is accepted.
- R5: A read of segment 0 fetches the word through one memory read and returns bits [15:0]. Later segments of that word return the held bits [16k+15:16k] without any memory request.
- R6: Each accepted transaction yields one single-cycle acknowledge on its own link. The two links are never acknowledged in the same cycle.
- R7: No acknowledge is given while a memory request is pending. The last write segment and the first read segment are acknowledged only after the grant.
- R8: A raised memory request stays high, with an unchanged address and direction, until the grant is seen. It drops in the cycle after the grant.
- R9: When only one link presents a transaction, that link is served. When both present in the same cycle, the point-to-point link is served first.
- R10: After the last segment of a word, that link's segment position returns to 0, so the next transaction starts a new word.
- R11: Each link keeps its own segment position and accumulator, so segments of words on the two links may interleave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p2p_valid | input | 1 | Point-to-point transaction present, held until acknowledge |
| p2p_write | input | 1 | 1 = write segment, 0 = read segment |
| p2p_addr | input | NET_AW | Network word address |
| p2p_wdata | input | SEG_W | Write segment |
| p2p_ack | output | 1 | One-cycle acknowledge |
| p2p_rdata | output | SEG_W | Read segment, valid with acknowledge |
| bus_valid | input | 1 | Bus transaction present, held until acknowledge |
| bus_write | input | 1 | 1 = write segment, 0 = read segment |
| bus_addr | input | NET_AW | Network word address |
| bus_wdata | input | SEG_W | Write segment |
| bus_ack | output | 1 | One-cycle acknowledge |
| bus_rdata | output | SEG_W | Read segment, valid with acknowledge |
| mem_req | output | 1 | Memory request towards the arbiter |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | MEM_AW | Translated shared-memory word address |
| mem_wdata | output | SEG_W*SEGS | Reassembled write word |
| mem_gnt | input | 1 | Arbiter grant for the pending request |
| mem_rdata | input | SEG_W*SEGS | Read word, valid the cycle after a read grant |

## Verification
Writes are tried as a plain two-segment word on one link, at the exact tile base, and back to back on one link. The back-to-back case shows that the position restarts after the last segment. Segments are also interleaved across both links, which separates per-link state from a shared accumulator. Simultaneous arrivals on both links expose the link priority. Reads of freshly written and of untouched words, counted against memory reads, show whether the held copy is used instead of a refetch. Grant delays of zero and several cycles show whether acknowledges wait for the arbiter. A network address below the base checks that translation wraps.

// File: rtl/ni_pkg.sv
package ni_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_WREQ,
    ST_RREQ,
    ST_RDAT
  } ni_state_e;

  localparam int NLINK    = 2;
  localparam int LINK_P2P = 0;
  localparam int LINK_BUS = 1;
endpackage

// File: rtl/ni_addr_map.sv
module ni_addr_map #(
  parameter int NET_AW     = 16,
  parameter int MEM_AW     = 10,
  parameter int TILE_BASE  = 'h0400,
  parameter int SHARED_OFS = 'h0200
) (
  input  logic [NET_AW-1:0] net_addr,
  output logic [MEM_AW-1:0] loc_addr
);
  logic [NET_AW-1:0] rel;

  // Offset inside this tile's window of the global map, rebased onto the shared region
  assign rel      = net_addr - NET_AW'(TILE_BASE);
  assign loc_addr = rel[MEM_AW-1:0] + MEM_AW'(SHARED_OFS);
endmodule

// File: rtl/ni_seg_lane.sv
module ni_seg_lane #(
  parameter int SEG_W = 16,
  parameter int SEGS  = 2,
  localparam int WORD_W = SEG_W * SEGS,
  localparam int CW     = (SEGS > 1) ? $clog2(SEGS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic              load_rd,
  input  logic [SEG_W-1:0]  seg_in,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              first,
  output logic              last,
  output logic [WORD_W-1:0] wr_word,
  output logic [SEG_W-1:0]  rd_seg
);
  logic [CW-1:0]     pos;
  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] held;

  assign first = (pos == '0);
  assign last  = (pos == CW'(SEGS - 1));

  // Full word as it stands once the incoming segment is merged in
  always_comb begin
    wr_word = acc;
    wr_word[pos*SEG_W +: SEG_W] = seg_in;
  end

  assign rd_seg = held[pos*SEG_W +: SEG_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      pos  <= '0;
      acc  <= '0;
      held <= '0;
    end else begin
      if (wr_stb)
        acc[pos*SEG_W +: SEG_W] <= seg_in;
      if (load_rd)
        held <= mem_rdata;
      if (wr_stb || rd_stb)
        pos <= last ? '0 : pos + CW'(1);
    end
  end
endmodule

// File: rtl/ni_ctrl.sv
module ni_ctrl
  import ni_pkg::*;
#(
  parameter int SEG_W  = 16,
  parameter int SEGS   = 2,
  parameter int MEM_AW = 10,
  localparam int WORD_W = SEG_W * SEGS
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NLINK-1:0]              valid,
  input  logic [NLINK-1:0]              write,
  input  logic [NLINK-1:0]              first,
  input  logic [NLINK-1:0]              last,
  input  logic [NLINK-1:0][MEM_AW-1:0]  xaddr,
  input  logic [NLINK-1:0][WORD_W-1:0]  wr_word,
  input  logic [NLINK-1:0][SEG_W-1:0]   rd_seg,
  output logic [NLINK-1:0]              wr_stb,
  output logic [NLINK-1:0]              rd_stb,
  output logic [NLINK-1:0]              load_rd,
  output logic [NLINK-1:0]              ack,
  output logic [NLINK-1:0][SEG_W-1:0]   rdata,
  output logic                          mem_req,
  output logic                          mem_we,
  output logic [MEM_AW-1:0]             mem_addr,
  output logic [WORD_W-1:0]             mem_wdata,
  input  logic                          mem_gnt,
  input  logic [WORD_W-1:0]             mem_rdata
);
  ni_state_e state;
  logic      sel;
  logic      pick;
  logic      any;

  // Point-to-point link wins a simultaneous arrival
  assign any  = |valid;
  assign pick = valid[LINK_P2P] ? 1'b0 : 1'b1;

  always_comb begin
    wr_stb  = '0;
    rd_stb  = '0;
    load_rd = '0;
    if (state == ST_IDLE && any) begin
      if (write[pick])
        wr_stb[pick] = 1'b1;
      else if (!first[pick])
        rd_stb[pick] = 1'b1;
    end
    if (state == ST_RDAT) begin
      load_rd[sel] = 1'b1;
      rd_stb[sel]  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      sel       <= 1'b0;
      ack       <= '0;
      rdata     <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      ack <= '0;
      case (state)
        ST_IDLE: if (any) begin
          sel <= pick;
          if (write[pick]) begin
            if (last[pick]) begin
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= xaddr[pick];
              mem_wdata <= wr_word[pick];
              state     <= ST_WREQ;
            end else begin
              ack[pick] <= 1'b1;
              state     <= ST_HOLD;
            end
          end else if (first[pick]) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= xaddr[pick];
            state    <= ST_RREQ;
          end else begin
            rdata[pick] <= rd_seg[pick];
            ack[pick]   <= 1'b1;
            state       <= ST_HOLD;
          end
        end
        ST_HOLD: state <= ST_IDLE;
        ST_WREQ: if (mem_gnt) begin
          mem_req  <= 1'b0;
          ack[sel] <= 1'b1;
          state    <= ST_HOLD;
        end
        ST_RREQ: if (mem_gnt) begin
          mem_req <= 1'b0;
          state   <= ST_RDAT;
        end
        ST_RDAT: begin
          rdata[sel] <= mem_rdata[SEG_W-1:0];
          ack[sel]   <= 1'b1;
          state      <= ST_HOLD;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: never both links at once, never two acknowledges in a row
  a_r6_ack_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(ack));
  a_r6_ack_pulse: assert property (@(posedge clk) disable iff (rst) (|ack) |=> !(|ack));
  // R7: acknowledges wait for the arbiter
  a_r7_no_ack_pending: assert property (@(posedge clk) disable iff (rst) mem_req |-> !(|ack));
  // R8: request held steady until granted, then released
  a_r8_req_held: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  a_r8_req_release: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_gnt) |=> !mem_req);
endmodule

// File: rtl/shared_slave_ni.sv
module shared_slave_ni
  import ni_pkg::*;
#(
  parameter int SEG_W      = 16,
  parameter int SEGS       = 2,
  parameter int NET_AW     = 16,
  parameter int MEM_AW     = 10,
  parameter int TILE_BASE  = 'h0400,
  parameter int SHARED_OFS = 'h0200,
  localparam int WORD_W = SEG_W * SEGS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              p2p_valid,
  input  logic              p2p_write,
  input  logic [NET_AW-1:0] p2p_addr,
  input  logic [SEG_W-1:0]  p2p_wdata,
  output logic              p2p_ack,
  output logic [SEG_W-1:0]  p2p_rdata,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [NET_AW-1:0] bus_addr,
  input  logic [SEG_W-1:0]  bus_wdata,
  output logic              bus_ack,
  output logic [SEG_W-1:0]  bus_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic [WORD_W-1:0] mem_rdata
);
  logic [NLINK-1:0]             lk_valid, lk_write, lk_first, lk_last;
  logic [NLINK-1:0]             wr_stb, rd_stb, load_rd, ack;
  logic [NLINK-1:0][NET_AW-1:0] lk_addr;
  logic [NLINK-1:0][SEG_W-1:0]  lk_wdata, rd_seg, rdata;
  logic [NLINK-1:0][MEM_AW-1:0] xaddr;
  logic [NLINK-1:0][WORD_W-1:0] wr_word;

  assign lk_valid = {bus_valid, p2p_valid};
  assign lk_write = {bus_write, p2p_write};
  assign lk_addr  = {bus_addr, p2p_addr};
  assign lk_wdata = {bus_wdata, p2p_wdata};

  assign p2p_ack   = ack[LINK_P2P];
  assign bus_ack   = ack[LINK_BUS];
  assign p2p_rdata = rdata[LINK_P2P];
  assign bus_rdata = rdata[LINK_BUS];

  for (genvar l = 0; l < NLINK; l++) begin : g_link
    ni_addr_map #(
      .NET_AW(NET_AW), .MEM_AW(MEM_AW),
      .TILE_BASE(TILE_BASE), .SHARED_OFS(SHARED_OFS)
    ) u_map (
      .net_addr(lk_addr[l]),
      .loc_addr(xaddr[l])
    );

    ni_seg_lane #(.SEG_W(SEG_W), .SEGS(SEGS)) u_lane (
      .clk(clk), .rst(rst),
      .wr_stb(wr_stb[l]), .rd_stb(rd_stb[l]), .load_rd(load_rd[l]),
      .seg_in(lk_wdata[l]), .mem_rdata(mem_rdata),
      .first(lk_first[l]), .last(lk_last[l]),
      .wr_word(wr_word[l]), .rd_seg(rd_seg[l])
    );
  end

  ni_ctrl #(.SEG_W(SEG_W), .SEGS(SEGS), .MEM_AW(MEM_AW)) u_ctrl (
    .clk(clk), .rst(rst),
    .valid(lk_valid), .write(lk_write), .first(lk_first), .last(lk_last),
    .xaddr(xaddr), .wr_word(wr_word), .rd_seg(rd_seg),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .load_rd(load_rd),
    .ack(ack), .rdata(rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
  );

  // R1: quiet outputs straight after reset
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (!mem_req && !p2p_ack && !bus_ack));
endmodule

// File: tb/shared_slave_ni_bench.sv
module shared_slave_ni_bench;
  localparam int BASE = 'h0400;
  localparam int OFS  = 'h0200;
  localparam int MDEP = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        vv [2];
  logic        ww [2];
  logic [15:0] aa [2];
  logic [15:0] dd [2];
  logic        p2p_ack, bus_ack, mem_req, mem_we, gnt;
  logic [15:0] p2p_rdata, bus_rdata;
  logic [9:0]  mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  shared_slave_ni u_shared_slave_ni (
    .clk(clk), .rst(rst),
    .p2p_valid(vv[0]), .p2p_write(ww[0]), .p2p_addr(aa[0]), .p2p_wdata(dd[0]),
    .p2p_ack(p2p_ack), .p2p_rdata(p2p_rdata),
    .bus_valid(vv[1]), .bus_write(ww[1]), .bus_addr(aa[1]), .bus_wdata(dd[1]),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(gnt), .mem_rdata(mem_rdata)
  );

  int nchk = 0, nerr = 0, cyc = 0, nwr = 0, nrd = 0;
  int gnt_delay = 0, wcnt = 0;
  logic [31:0] mem [MDEP];
  logic [31:0] ref_mem [MDEP];
  int          q_addr [$];
  logic [31:0] q_data [$];
  logic        prev_ack0 = 1'b0, prev_ack1 = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int xl(input int a);
    return (((a - BASE + OFS) % MDEP) + MDEP) % MDEP;
  endfunction

  always @(posedge clk) cyc++;

  // Arbiter model: grant after gnt_delay waiting cycles, for one cycle
  always @(negedge clk) begin
    if (rst) begin gnt = 1'b0; wcnt = 0; end
    else if (gnt) begin gnt = 1'b0; wcnt = 0; end
    else if (mem_req) begin
      if (wcnt >= gnt_delay) gnt = 1'b1;
      else wcnt++;
    end
  end

  // Memory model plus write monitor against the expected-write queue
  always @(posedge clk) begin
    if (!rst && mem_req && gnt) begin
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        nwr++;
        if (q_addr.size() == 0) chk("R3 unexpected write", 32'(mem_addr), 32'hFFFFFFFF);
        else begin
          chk("R2 write address", 32'(mem_addr), 32'(q_addr.pop_front()));
          chk("R3 write word", mem_wdata, q_data.pop_front());
        end
      end else begin
        mem_rdata <= mem[mem_addr];
        nrd++;
      end
    end
  end

  // Per-cycle acknowledge rules
  always @(negedge clk) begin
    if (!rst) begin
      if (p2p_ack || bus_ack) begin
        nchk++;
        if (p2p_ack && bus_ack) begin nerr++; $display("FAIL R6: actual both acks expected one"); end
        if ((p2p_ack && prev_ack0) || (bus_ack && prev_ack1)) begin
          nerr++; $display("FAIL R6: actual ack two cycles expected one");
        end
        if (mem_req) begin nerr++; $display("FAIL R7: actual ack with mem_req=1 expected mem_req=0"); end
      end
      prev_ack0 = p2p_ack;
      prev_ack1 = bus_ack;
    end
  end

  task automatic txn(input int lk, input logic wr, input logic [15:0] a, input logic [15:0] d,
                     output logic [15:0] rd, output int lat, output int tdone);
    @(negedge clk);
    vv[lk] = 1'b1; ww[lk] = wr; aa[lk] = a; dd[lk] = d;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!(lk == 0 ? p2p_ack : bus_ack) && lat < 500);
    rd = (lk == 0) ? p2p_rdata : bus_rdata;
    tdone = cyc;
    vv[lk] = 1'b0;
  endtask

  task automatic seg_wr(input int lk, input logic [15:0] a, input logic [15:0] d, input bit is_last);
    logic [15:0] rd; int lat, td, w0;
    w0 = nwr;
    txn(lk, 1'b1, a, d, rd, lat, td);
    if (!is_last) begin
      chk("R4 write ack latency", 32'(lat), 32'd1);
      chk("R3 no write before last segment", 32'(nwr), 32'(w0));
    end
  endtask

  task automatic word_wr(input int lk, input logic [15:0] a, input logic [31:0] w);
    seg_wr(lk, a, w[15:0], 1'b0);
    q_addr.push_back(xl(int'(a))); q_data.push_back(w);
    ref_mem[xl(int'(a))] = w;
    seg_wr(lk, a, w[31:16], 1'b1);
  endtask

  task automatic word_rd(input int lk, input logic [15:0] a, input string tag);
    logic [15:0] rd; int lat, td, r0;
    logic [31:0] exp;
    exp = ref_mem[xl(int'(a))];
    r0 = nrd;
    txn(lk, 1'b0, a, 16'h0, rd, lat, td);
    chk({"R5 low segment ", tag}, 32'(rd), 32'(exp[15:0]));
    chk("R5 one fetch for segment 0", 32'(nrd), 32'(r0 + 1));
    txn(lk, 1'b0, a, 16'h0, rd, lat, td);
    chk({"R5 high segment ", tag}, 32'(rd), 32'(exp[31:16]));
    chk("R5 no fetch for later segment", 32'(nrd), 32'(r0 + 1));
    chk("R4 read ack latency", 32'(lat), 32'd1);
  endtask

  initial begin
    for (int l = 0; l < 2; l++) begin vv[l] = 1'b0; ww[l] = 1'b0; aa[l] = '0; dd[l] = '0; end
    for (int i = 0; i < MDEP; i++) begin
      mem[i]     = 32'h5A000000 ^ (i * 32'h00010003);
      ref_mem[i] = 32'h5A000000 ^ (i * 32'h00010003);
    end
    mem_rdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 p2p_ack", 32'(p2p_ack), 0);
    chk("R1 bus_ack", 32'(bus_ack), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    rst = 1'b0;

    // R3 R7: plain word on the p2p link with a slow grant
    gnt_delay = 3;
    word_wr(0, 16'h0410, 32'hDEADBEEF);
    word_rd(0, 16'h0410, "p2p");

    // R2 R9: bus alone at the exact tile base, immediate grant
    gnt_delay = 0;
    word_wr(1, 16'h0400, 32'h12345678);
    word_rd(1, 16'h0400, "bus base");

    // R11: interleaved segments of words on both links
    gnt_delay = 1;
    seg_wr(0, 16'h0420, 16'hAAAA, 1'b0);
    seg_wr(1, 16'h0430, 16'h5555, 1'b0);
    q_addr.push_back(xl('h0420)); q_data.push_back(32'hCCCCAAAA); ref_mem[xl('h0420)] = 32'hCCCCAAAA;
    seg_wr(0, 16'h0420, 16'hCCCC, 1'b1);
    q_addr.push_back(xl('h0430)); q_data.push_back(32'h33335555); ref_mem[xl('h0430)] = 32'h33335555;
    seg_wr(1, 16'h0430, 16'h3333, 1'b1);
    word_rd(1, 16'h0420, "R11 cross-link");
    word_rd(0, 16'h0430, "R11 cross-link");

    // R9: both links present in the same cycle
    begin
      logic [15:0] r0, r1; int l0, l1, t0, t1;
      fork
        txn(0, 1'b1, 16'h0440, 16'h1111, r0, l0, t0);
        txn(1, 1'b1, 16'h0450, 16'h2222, r1, l1, t1);
      join
      chk("R9 p2p served first", 32'(t0 < t1), 32'd1);
      chk("R9 p2p latency", 32'(l0), 32'd1);
    end
    q_addr.push_back(xl('h0440)); q_data.push_back(32'h99991111); ref_mem[xl('h0440)] = 32'h99991111;
    seg_wr(0, 16'h0440, 16'h9999, 1'b1);
    q_addr.push_back(xl('h0450)); q_data.push_back(32'h88882222); ref_mem[xl('h0450)] = 32'h88882222;
    seg_wr(1, 16'h0450, 16'h8888, 1'b1);

    // R10: back-to-back words on one link
    gnt_delay = 2;
    word_wr(1, 16'h0460, 32'hCAFE0001);
    word_wr(1, 16'h0461, 32'hF00D0002);
    word_rd(1, 16'h0460, "R10 first");
    word_rd(1, 16'h0461, "R10 second");

    // R2: untouched words, top of region and an address below the base (wraps)
    word_rd(0, 16'h05F0, "R2 top");
    word_rd(0, 16'h0300, "R2 wrap");
    word_wr(0, 16'h0300, 32'h0BADF00D);
    word_rd(1, 16'h0300, "R2 wrap written");

    repeat (4) @(negedge clk);
    chk("R3 all expected writes seen", 32'(q_addr.size()), 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule